// File: doc/BRIEF.md
# Mixed-Sign Int8 Dot Product Unit

This block is the integer dot-product datapath of a SIMD unit. It treats each 32-bit lane of the result as an accumulator. Each accumulator adds four 8-bit by 8-bit products, and the bytes of those products come from the matching 32-bit group of two source vectors. The two operands can have different signedness. In one mode the first source is unsigned and the second is signed. In another mode the first source is signed and the second is unsigned.

A width select picks a 64-bit form with two lanes or a 128-bit form with four lanes. There are two ways to choose the second operand. In the plain vector mode, each lane uses its own group of the second source. In the by-element mode, a 2-bit index picks one 32-bit group of the second source, and that group is sent to every lane.

The products are computed combinationally in the same cycle. The result is captured in an output register. A two-state control machine raises a valid flag one cycle after the input valid.

Top module: `mixdot_unit`

## Requirements
- R1: Each active lane i of `acc_out` equals `acc_in` lane i plus the sum of the four byte products taken from the lane's groups, where byte k of a group occupies bits 8k+7:8k of it. The addition wraps modulo 2^32.
- R2: `mode` = 2'b00 (vector, unsigned-by-signed) uses group i of `src_b` for lane i. It treats the `src_a` bytes as unsigned (0..255) and the `src_b` bytes as signed (-128..127).
- R3: `mode` = 2'b01 (by-element, unsigned-by-signed) uses group `grp_sel` of `src_b` (bits 32*grp_sel+31:32*grp_sel) for every lane. The signedness is the same as in R2.
- R4: `mode` = 2'b10 (by-element, signed-by-unsigned) selects the broadcast group as in R3. It treats the `src_a` bytes as signed and the `src_b` bytes as unsigned.
- R5: `mode` = 2'b11 is reserved. It adds no products, so each active lane equals its `acc_in` lane.
- R6: With `wide` = 0, only lanes 0 and 1 are computed and `acc_out[127:64]` is zero. With `wide` = 1, all four lanes are computed.
- R7: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `acc_out` loads only on an accepted operation and otherwise holds its value.
- R8: After reset, `out_valid` is 0 and `acc_out` is zero.
- R9: The accumulation does not saturate. A sum past 2^31-1 wraps to a negative value.

Control states: `ST_EMPTY` (no result pending) and `ST_FULL` (result valid). The transitions are:
- take: `ST_EMPTY` to `ST_FULL` on `in_valid`.
- stream: `ST_FULL` to `ST_FULL` on `in_valid`.
- drain: `ST_FULL` to `ST_EMPTY` without `in_valid`.
- idle: `ST_EMPTY` to `ST_EMPTY` without `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation presented this cycle |
| mode | input | 2 | Operand variant (R2 to R5 encodings) |
| wide | input | 1 | 1 = 128-bit four-lane form, 0 = 64-bit two-lane form |
| grp_sel | input | 2 | Broadcast group index for by-element modes |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| acc_in | input | 128 | Accumulator vector |
| out_valid | output | 1 | Result valid |
| acc_out | output | 128 | Updated accumulator |

## Verification
The hardest cases to reach are the sign-extension extremes. A byte of 0x80 or 0xFF means -128 or -1 on one side and 128 or 255 on the other. Any swap of the signedness between the two operands only shows up when such a byte meets a large value on the other side.

The bench therefore sweeps every `src_a` byte value against a dense stride of `src_b` values in both mixed modes. It fills all four byte positions of every lane, so the largest-magnitude sums are produced. It then walks every mode, width and group index with random operands, and adds a forced wrap past 2^31-1.

// File: rtl/mixdot_pkg.sv
package mixdot_pkg;
    typedef enum logic [1:0] {
        MD_VEC_US  = 2'b00,
        MD_ELEM_US = 2'b01,
        MD_ELEM_SU = 2'b10,
        MD_RSVD    = 2'b11
    } md_mode_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } md_state_e;
endpackage

// File: rtl/mixdot_opsel.sv
module mixdot_opsel
    import mixdot_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 32,
    localparam int VEC_W = LANES * LANE_W,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [1:0]       mode,
    input  logic [IDX_W-1:0] grp_sel,
    input  logic [VEC_W-1:0] src_b,
    output logic [VEC_W-1:0] b_lanes,
    output logic             a_signed,
    output logic             b_signed,
    output logic             prod_en
);
    md_mode_e   m;
    logic [LANE_W-1:0] bcast;

    assign m     = md_mode_e'(mode);
    assign bcast = src_b[grp_sel*LANE_W +: LANE_W];

    always_comb begin
        unique case (m)
            MD_VEC_US:  begin a_signed = 1'b0; b_signed = 1'b1; prod_en = 1'b1; end
            MD_ELEM_US: begin a_signed = 1'b0; b_signed = 1'b1; prod_en = 1'b1; end
            MD_ELEM_SU: begin a_signed = 1'b1; b_signed = 1'b0; prod_en = 1'b1; end
            MD_RSVD:    begin a_signed = 1'b0; b_signed = 1'b0; prod_en = 1'b0; end
            default:    begin a_signed = 1'b0; b_signed = 1'b0; prod_en = 1'b0; end
        endcase
    end

    for (genvar l = 0; l < LANES; l++) begin : g_bsel
        assign b_lanes[l*LANE_W +: LANE_W] =
            (m == MD_VEC_US) ? src_b[l*LANE_W +: LANE_W] : bcast;
    end
endmodule

// File: rtl/mixdot_lane.sv
module mixdot_lane #(
    parameter int LANE_W = 32,
    parameter int ELEM_W = 8,
    localparam int NELEM = LANE_W / ELEM_W,
    localparam int EXT_W = ELEM_W + 1,
    localparam int PRD_W = 2 * EXT_W,
    localparam int SUM_W = PRD_W + $clog2(NELEM)
) (
    input  logic [LANE_W-1:0] a_word,
    input  logic [LANE_W-1:0] b_word,
    input  logic [LANE_W-1:0] acc_word,
    input  logic              a_signed,
    input  logic              b_signed,
    input  logic              prod_en,
    output logic [LANE_W-1:0] res_word
);
    logic signed [SUM_W-1:0] total;

    always_comb begin
        total = '0;
        for (int k = 0; k < NELEM; k++) begin
            logic signed [EXT_W-1:0] ea;
            logic signed [EXT_W-1:0] eb;
            logic signed [PRD_W-1:0] pr;
            ea = {a_signed & a_word[k*ELEM_W + ELEM_W-1], a_word[k*ELEM_W +: ELEM_W]};
            eb = {b_signed & b_word[k*ELEM_W + ELEM_W-1], b_word[k*ELEM_W +: ELEM_W]};
            pr = ea * eb;
            total = total + {{(SUM_W-PRD_W){pr[PRD_W-1]}}, pr};
        end
        if (prod_en)
            res_word = acc_word + {{(LANE_W-SUM_W){total[SUM_W-1]}}, total};
        else
            res_word = acc_word;
    end
endmodule

// File: rtl/mixdot_unit.sv
module mixdot_unit
    import mixdot_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 32,
    parameter int ELEM_W = 8,
    localparam int VEC_W = LANES * LANE_W,
    localparam int IDX_W = $clog2(LANES),
    localparam int HALF  = LANES / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       mode,
    input  logic             wide,
    input  logic [IDX_W-1:0] grp_sel,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [VEC_W-1:0] acc_in,
    output logic             out_valid,
    output logic [VEC_W-1:0] acc_out
);
    md_state_e state, state_nx;
    logic [VEC_W-1:0] b_lanes;
    logic [VEC_W-1:0] lane_res;
    logic [VEC_W-1:0] masked;
    logic a_sgn, b_sgn, p_en;

    mixdot_opsel #(.LANES(LANES), .LANE_W(LANE_W)) u_opsel (
        .mode(mode), .grp_sel(grp_sel), .src_b(src_b),
        .b_lanes(b_lanes), .a_signed(a_sgn), .b_signed(b_sgn), .prod_en(p_en)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        mixdot_lane #(.LANE_W(LANE_W), .ELEM_W(ELEM_W)) u_lane (
            .a_word(src_a[l*LANE_W +: LANE_W]),
            .b_word(b_lanes[l*LANE_W +: LANE_W]),
            .acc_word(acc_in[l*LANE_W +: LANE_W]),
            .a_signed(a_sgn), .b_signed(b_sgn), .prod_en(p_en),
            .res_word(lane_res[l*LANE_W +: LANE_W])
        );
        if (l < HALF) begin : g_low
            assign masked[l*LANE_W +: LANE_W] = lane_res[l*LANE_W +: LANE_W];
        end else begin : g_high
            assign masked[l*LANE_W +: LANE_W] =
                wide ? lane_res[l*LANE_W +: LANE_W] : '0;
        end
    end

    // next-state logic: take / stream / drain / idle
    always_comb begin
        unique case (state)
            ST_EMPTY: state_nx = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_nx = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_nx = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        acc_out <= '0;
        else if (in_valid) acc_out <= masked;
    end

    always_comb begin
        out_valid = (state == ST_FULL);
    end

    assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(acc_out));

    assert_narrow_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && !$past(wide)) |-> (acc_out[VEC_W-1:HALF*LANE_W] == '0));

    assert_reserved_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && ($past(mode) == 2'b11))
            |-> (acc_out[HALF*LANE_W-1:0] == $past(acc_in[HALF*LANE_W-1:0])));
endmodule

// File: tb/test_mixdot_unit.sv
`timescale 1ns/1ps
module test_mixdot_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic         wide = 1'b1;
    logic [1:0]   grp_sel = 2'b00;
    logic [127:0] src_a = '0, src_b = '0, acc_in = '0;
    logic         out_valid;
    logic [127:0] acc_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mixdot_unit i_mixdot_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .wide(wide),
        .grp_sel(grp_sel), .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
        .out_valid(out_valid), .acc_out(acc_out)
    );

    function automatic logic [127:0] model(input logic [1:0] m, input logic w,
        input logic [1:0] ix, input logic [127:0] a, input logic [127:0] b,
        input logic [127:0] acc);
        logic [127:0] r = '0;
        for (int l = 0; l < 4; l++) begin
            logic [31:0] bw;
            logic [31:0] s;
            if (!w && l >= 2) continue;
            bw = (m == 2'b00) ? b[l*32 +: 32] : b[ix*32 +: 32];
            s = acc[l*32 +: 32];
            if (m != 2'b11) begin
                for (int k = 0; k < 4; k++) begin
                    logic [7:0] ab, bb;
                    int va, vb;
                    ab = a[l*32 + k*8 +: 8];
                    bb = bw[k*8 +: 8];
                    va = (m == 2'b10) ? int'($signed(ab)) : int'(ab);
                    vb = (m == 2'b10) ? int'(bb) : int'($signed(bb));
                    s = s + 32'(va * vb);
                end
            end
            r[l*32 +: 32] = s;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [1:0] m, input logic w,
        input logic [1:0] ix, input logic [127:0] a, input logic [127:0] b,
        input logic [127:0] acc);
        @(negedge clk);
        in_valid = 1'b1; mode = m; wide = w; grp_sel = ix;
        src_a = a; src_b = b; acc_in = acc;
        @(negedge clk);
        check({tag, " out_valid R7"}, {127'd0, out_valid}, 128'd1);
        check(tag, acc_out, model(m, w, ix, a, b, acc));
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 reset out_valid", {127'd0, out_valid}, 128'd0);
        check("R8 reset acc_out", acc_out, 128'd0);
        rst_n = 1'b1;

        // R2 and R4 sweeps: every a byte against a stride of b bytes, all positions
        for (int av = 0; av < 256; av++) begin
            for (int bv = 0; bv < 256; bv += 3) begin
                logic [127:0] a, b, acc;
                a = {16{8'(av)}};
                b = {16{8'(bv)}};
                acc = rnd128();
                apply("R2 R1 vector sweep", 2'b00, 1'b1, 2'(bv), a, b, acc);
                apply("R4 R1 elem sweep", 2'b10, 1'b1, 2'(av), a, b, acc);
            end
        end
        // edge bytes explicitly
        apply("R2 edge 0xFF*0x80", 2'b00, 1'b1, 2'd0, {16{8'hFF}}, {16{8'h80}}, '0);
        apply("R4 edge 0x80*0xFF", 2'b10, 1'b1, 2'd3, {16{8'h80}}, {16{8'hFF}}, '0);

        // every mode, width and index with random operands
        for (int m = 0; m < 4; m++) begin
            for (int w = 0; w < 2; w++) begin
                for (int ix = 0; ix < 4; ix++) begin
                    for (int r = 0; r < 40; r++) begin
                        string tg;
                        tg = (m == 0) ? "R2 vector" : (m == 1) ? "R3 by-element" :
                             (m == 2) ? "R4 by-element" : "R5 reserved";
                        if (w == 0) tg = {tg, " R6 narrow"};
                        apply(tg, 2'(m), 1'(w), 2'(ix), rnd128(), rnd128(), rnd128());
                    end
                end
            end
        end
        // R3: distinct groups in src_b, check broadcast of each index
        for (int ix = 0; ix < 4; ix++)
            apply("R3 broadcast group", 2'b01, 1'b1, 2'(ix), {16{8'h01}},
                  {32'h7F7F7F7F, 32'h80808080, 32'h01020304, 32'hFFFFFFFF}, '0);

        // R6: narrow with nonzero upper accumulator must still clear upper half
        apply("R6 upper zero", 2'b00, 1'b0, 2'd0, {128{1'b1}}, {128{1'b1}}, {128{1'b1}});
        check("R6 upper bits", {64'd0, acc_out[127:64]}, 128'd0);

        // R9: wrap past 2^31-1
        apply("R9 wrap", 2'b00, 1'b1, 2'd0, {16{8'hFF}}, {16{8'h7F}}, {4{32'h7FFFFFFF}});
        check("R9 wrap lane0", {96'd0, acc_out[31:0]}, {96'd0, 32'h7FFFFFFF + 32'd129540});

        // R7: hold when idle
        begin
            logic [127:0] held;
            held = acc_out;
            @(negedge clk);
            in_valid = 1'b0; src_a = rnd128(); src_b = rnd128(); acc_in = rnd128(); mode = 2'b01;
            @(negedge clk);
            check("R7 drain valid", {127'd0, out_valid}, 128'd0);
            check("R7 hold", acc_out, held);
            @(negedge clk);
            check("R7 idle hold", acc_out, held);
            check("R7 idle valid", {127'd0, out_valid}, 128'd0);
        end
        apply("R7 restart", 2'b10, 1'b0, 2'd2, rnd128(), rnd128(), rnd128());

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R7 act=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule